// File: doc/BRIEF.md
# Programmable Address Lookup Table

This unit sits on a core's outbound physical address path, in front of its mesh interface. The top eight bits of each 32-bit request address select one of 256 programmable entries, so each entry governs a 16 MB window. An entry supplies ten replacement upper address bits, which replace the eight index bits. It also names a destination tile by column and row, and an endpoint type inside that tile: a memory port, the configuration and voltage register block, or the local message buffer. Each entry also carries a flag that marks its window as shared, so that software handles coherence for that window. Private windows are left to hardware coherence.

Any entry can be rewritten while traffic flows, through a one-cycle write port. After reset, only a single boot entry is valid, and it points at memory controller 0. A lookup returns one clock after the request. A lookup that lands on an invalid entry raises an error and sends no outgoing request.

Top module: `addr_route_lut`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rsp_valid` and `rsp_err` are 0. After reset, every entry except the boot index is invalid.
- R2: After reset, the boot index (default 255) holds a valid private entry with tile column 0, tile row 0, endpoint type 0 (memory controller) and upper address bits `BOOT_HI` (default 10'h0FF).
- R3: A request with `req_valid` high at a rising edge produces exactly one of `rsp_valid` or `rsp_err` in the following cycle. With no request, both are 0.
- R4: On a hit, `rsp_addr` equals the entry's 10-bit upper field concatenated above `req_addr[23:0]`, and the low 24 bits pass through unchanged.
- R5: On a hit, `rsp_dest_x`, `rsp_dest_y` and `rsp_subdest` equal the entry fields. Endpoint type codes are 0 memory, 1 configuration registers, 2 message buffer.
- R6: On a hit, `rsp_shared` equals the entry's shared bit.
- R7: A request whose entry has its valid bit clear gives `rsp_err`=1 and `rsp_valid`=0. All routing outputs, `rsp_addr` and `rsp_shared` are 0 in that case.
- R8: A write with `cfg_we` high stores `cfg_entry` at `cfg_idx`, and lookups from the next cycle onward see it. The entry layout from MSB to LSB is valid[19], shared[18], column[17:15], row[14:13], endpoint[12:10], upper address[9:0].
- R9: When a write and a lookup address the same index at the same edge, the lookup returns the contents from before the write.
- R10: `rsp_valid` and `rsp_err` are never high together.
- R11: With `cfg_we` low, `cfg_idx` and `cfg_entry` change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Physical request address |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 8 | Entry index to write |
| cfg_entry | input | 20 | Entry contents to write |
| rsp_valid | output | 1 | Outgoing translated request valid |
| rsp_err | output | 1 | Lookup hit an invalid entry |
| rsp_addr | output | 34 | Translated address |
| rsp_shared | output | 1 | Window is software-coherent |
| rsp_dest_x | output | 3 | Destination tile column |
| rsp_dest_y | output | 2 | Destination tile row |
| rsp_subdest | output | 3 | Endpoint type inside the tile |

## Verification
The hardest case to reach is a write and a lookup colliding on the same index at the same edge. Here the response must reflect the entry as it was before the write, while every later lookup sees the new contents. The stimulus drives both ports in one cycle, once turning an invalid entry valid and once altering a valid one. The reference model records the expected result before it applies the write. A lookup to the same index follows immediately, which confirms that the write did land.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 8;
    localparam int OFF_W   = ADDR_W - IDX_W;
    localparam int HI_W    = 10;
    localparam int XADDR_W = HI_W + OFF_W;
    localparam int X_W     = 3;
    localparam int Y_W     = 2;
    localparam int SUB_W   = 3;
    localparam int N_ENT   = 1 << IDX_W;

    typedef enum logic [SUB_W-1:0] {
        SUB_MEM    = 3'd0,
        SUB_CFG    = 3'd1,
        SUB_MSGBUF = 3'd2
    } subdest_e;

    typedef struct packed {
        logic             valid;
        logic             shared;
        logic [X_W-1:0]   dx;
        logic [Y_W-1:0]   dy;
        logic [SUB_W-1:0] sub;
        logic [HI_W-1:0]  hi;
    } lut_entry_t;

    localparam int ENT_W = $bits(lut_entry_t);

    typedef struct packed {
        logic               ok;
        logic               err;
        logic [XADDR_W-1:0] addr;
        logic               shared;
        logic [X_W-1:0]     dx;
        logic [Y_W-1:0]     dy;
        logic [SUB_W-1:0]   sub;
    } lut_rsp_t;

    function automatic lut_rsp_t form_rsp(input lut_entry_t e,
                                          input logic [OFF_W-1:0] off,
                                          input logic pend);
        lut_rsp_t r;
        r = '0;
        if (pend) begin
            if (e.valid) begin
                r.ok     = 1'b1;
                r.addr   = {e.hi, off};
                r.shared = e.shared;
                r.dx     = e.dx;
                r.dy     = e.dy;
                r.sub    = e.sub;
            end else begin
                r.err = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lut_entry_reg.sv
module lut_entry_reg
    import xlat_pkg::*;
#(
    parameter lut_entry_t RST_VAL = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  lut_entry_t wdata,
    output lut_entry_t q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= wdata;
    end

endmodule

// File: rtl/lut_bank.sv
module lut_bank
    import xlat_pkg::*;
#(
    parameter int              BOOT_IDX = 255,
    parameter lut_entry_t      BOOT_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  lut_entry_t       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output lut_entry_t       rd_q
);

    lut_entry_t ent [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        localparam lut_entry_t RV = (i == BOOT_IDX) ? BOOT_VAL : '0;
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));
        lut_entry_reg #(.RST_VAL(RV)) u_ent (
            .clk   (clk),
            .rst   (rst),
            .we    (sel),
            .wdata (wr_data),
            .q     (ent[i])
        );
    end

    // Registered read sees pre-write contents on a same-edge collision.
    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= ent[rd_idx];
    end

endmodule

// File: rtl/lut_resp.sv
module lut_resp
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_off,
    input  lut_entry_t       ent_q,
    output lut_rsp_t         rsp
);

    logic             pend_q;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            off_q  <= '0;
        end else begin
            pend_q <= req_valid;
            off_q  <= req_off;
        end
    end

    assign rsp = form_rsp(ent_q, off_q, pend_q);

endmodule

// File: rtl/addr_route_lut.sv
module addr_route_lut
    import xlat_pkg::*;
#(
    parameter int              BOOT_IDX = 255,
    parameter logic [9:0]      BOOT_HI  = 10'h0FF,
    parameter logic [2:0]      BOOT_X   = 3'd0,
    parameter logic [1:0]      BOOT_Y   = 2'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_idx,
    input  logic [19:0] cfg_entry,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [33:0] rsp_addr,
    output logic        rsp_shared,
    output logic [2:0]  rsp_dest_x,
    output logic [1:0]  rsp_dest_y,
    output logic [2:0]  rsp_subdest
);

    localparam lut_entry_t BOOT_VAL = '{
        valid:  1'b1,
        shared: 1'b0,
        dx:     BOOT_X,
        dy:     BOOT_Y,
        sub:    SUB_MEM,
        hi:     BOOT_HI
    };

    lut_entry_t ent_q;
    lut_rsp_t   rsp;

    lut_bank #(.BOOT_IDX(BOOT_IDX), .BOOT_VAL(BOOT_VAL)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (lut_entry_t'(cfg_entry)),
        .rd_idx  (req_addr[ADDR_W-1 -: IDX_W]),
        .rd_q    (ent_q)
    );

    lut_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_off   (req_addr[OFF_W-1:0]),
        .ent_q     (ent_q),
        .rsp       (rsp)
    );

    assign rsp_valid   = rsp.ok;
    assign rsp_err     = rsp.err;
    assign rsp_addr    = rsp.addr;
    assign rsp_shared  = rsp.shared;
    assign rsp_dest_x  = rsp.dx;
    assign rsp_dest_y  = rsp.dy;
    assign rsp_subdest = rsp.sub;

endmodule

// File: rtl/addr_route_lut_chk.sv
module addr_route_lut_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [33:0] rsp_addr,
    input logic        rsp_shared,
    input logic [2:0]  rsp_dest_x,
    input logic [1:0]  rsp_dest_y,
    input logic [2:0]  rsp_subdest
);

    a_r3_answer_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_valid || rsp_err));

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_err));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_err));

    a_r4_offset_pass: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid) && rsp_valid) |->
            (rsp_addr[23:0] == $past(req_addr[23:0])));

    a_r7_err_quiet: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_addr == '0 && !rsp_shared && rsp_dest_x == '0
                     && rsp_dest_y == '0 && rsp_subdest == '0));

endmodule

bind addr_route_lut addr_route_lut_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_addr    (rsp_addr),
    .rsp_shared  (rsp_shared),
    .rsp_dest_x  (rsp_dest_x),
    .rsp_dest_y  (rsp_dest_y),
    .rsp_subdest (rsp_subdest)
);

// File: tb/addr_route_lut_tb_top.sv
module addr_route_lut_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    typedef struct {
        logic        v;
        logic        e;
        logic [33:0] a;
        logic        s;
        logic [2:0]  x;
        logic [1:0]  y;
        logic [2:0]  u;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        cfg_we;
    logic [7:0]  cfg_idx;
    logic [19:0] cfg_entry;
    logic        rsp_valid, rsp_err, rsp_shared;
    logic [33:0] rsp_addr;
    logic [2:0]  rsp_dest_x, rsp_subdest;
    logic [1:0]  rsp_dest_y;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];
    logic [19:0] model [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_route_lut dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_entry(cfg_entry),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr),
        .rsp_shared(rsp_shared), .rsp_dest_x(rsp_dest_x),
        .rsp_dest_y(rsp_dest_y), .rsp_subdest(rsp_subdest)
    );

    function automatic logic [19:0] mk(input logic v, input logic s,
                                       input logic [2:0] x, input logic [1:0] y,
                                       input logic [2:0] u, input logic [9:0] h);
        return {v, s, x, y, u, h};
    endfunction

    function automatic exp_t predict(input logic [31:0] a, input string tag);
        exp_t r;
        logic [19:0] e;
        e = model[a[31:24]];
        r = '{v: 1'b0, e: 1'b0, a: '0, s: 1'b0, x: '0, y: '0, u: '0, tag: tag};
        if (e[19]) begin
            r.v = 1'b1; r.s = e[18]; r.x = e[17:15]; r.y = e[14:13];
            r.u = e[12:10]; r.a = {e[9:0], a[23:0]};
        end else begin
            r.e = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Driver: one cycle of stimulus; expectation taken before the write lands.
    task automatic step(input bit rq, input logic [31:0] a, input bit we,
                        input logic [7:0] ix, input logic [19:0] d,
                        input string tag);
        @(negedge clk);
        req_valid = rq; req_addr = a;
        cfg_we = we; cfg_idx = ix; cfg_entry = d;
        if (rq) sb_q.push_back(predict(a, tag));
        if (we) model[ix] = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b0, 8'h0, 20'h0, "");
    endtask

    // Monitor: a quarter period after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (!rst) begin
                if (sb_q.size() > 0) begin
                    exp_t x;
                    x = sb_q.pop_front();
                    check(rsp_valid == x.v && rsp_err == x.e, x.tag,
                          $sformatf("valid/err act=%b/%b exp=%b/%b",
                                    rsp_valid, rsp_err, x.v, x.e));
                    check(rsp_addr == x.a, x.tag,
                          $sformatf("addr act=%h exp=%h", rsp_addr, x.a));
                    check({rsp_shared, rsp_dest_x, rsp_dest_y, rsp_subdest}
                          == {x.s, x.x, x.y, x.u}, x.tag,
                          $sformatf("route act=%b_%h_%h_%h exp=%b_%h_%h_%h",
                                    rsp_shared, rsp_dest_x, rsp_dest_y, rsp_subdest,
                                    x.s, x.x, x.y, x.u));
                end else begin
                    check(!rsp_valid && !rsp_err, "R3",
                          $sformatf("idle act=%b/%b exp=0/0", rsp_valid, rsp_err));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WDOG_CYC);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        model[255] = mk(1'b1, 1'b0, 3'd0, 2'd0, 3'd0, 10'h0FF);
        rst = 1'b1; req_valid = 1'b0; req_addr = '0;
        cfg_we = 1'b0; cfg_idx = '0; cfg_entry = '0;
        // R1: outputs quiet in reset, even with a request presented
        repeat (2) @(negedge clk);
        req_valid = 1'b1; req_addr = 32'hFF00_0000;
        @(posedge clk); #(CLK_PERIOD/4);
        check(!rsp_valid && !rsp_err, "R1",
              $sformatf("reset act=%b/%b exp=0/0", rsp_valid, rsp_err));
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b0;
        idle(1);
        // R1 and R7: non-boot entries invalid after reset
        step(1'b1, 32'h0000_0001, 1'b0, 0, 0, "R1");
        step(1'b1, 32'h12AB_CDEF, 1'b0, 0, 0, "R7");
        step(1'b1, 32'h80FF_FFFF, 1'b0, 0, 0, "R1");
        // R2: boot entry
        step(1'b1, 32'hFF12_3456, 1'b0, 0, 0, "R2");
        idle(2);
        // R8, R4, R5: program and look up
        step(1'b0, 0, 1'b1, 8'h10, mk(1, 0, 3'd5, 2'd2, 3'd2, 10'h123), "");
        step(1'b1, 32'h10AB_CDEF, 1'b0, 0, 0, "R8");
        step(1'b1, 32'h1000_0000, 1'b0, 0, 0, "R4");
        step(1'b1, 32'h10FF_FFFF, 1'b0, 0, 0, "R5");
        // R6: shared window to config registers
        step(1'b0, 0, 1'b1, 8'h20, mk(1, 1, 3'd7, 2'd3, 3'd1, 10'h3C1), "");
        step(1'b1, 32'h2055_AA55, 1'b0, 0, 0, "R6");
        // R9: collision on an invalid entry turning valid
        step(1'b1, 32'h3001_0203, 1'b1, 8'h30, mk(1, 0, 3'd2, 2'd1, 3'd0, 10'h2AA), "R9");
        step(1'b1, 32'h3001_0203, 1'b0, 0, 0, "R8");
        // R9: collision altering a valid entry
        step(1'b1, 32'h1012_3456, 1'b1, 8'h10, mk(1, 1, 3'd1, 2'd0, 3'd1, 10'h001), "R9");
        step(1'b1, 32'h1012_3456, 1'b0, 0, 0, "R8");
        // R11: data on the write port with strobe low is ignored
        step(1'b0, 0, 1'b0, 8'h10, mk(0, 0, 3'd3, 2'd3, 3'd3, 10'h155), "");
        step(1'b0, 0, 1'b0, 8'h41, mk(1, 1, 3'd6, 2'd1, 3'd2, 10'h2F0), "");
        step(1'b1, 32'h1077_7777, 1'b0, 0, 0, "R11");
        step(1'b1, 32'h4100_0000, 1'b0, 0, 0, "R11");
        // R7: invalidate a programmed entry
        step(1'b0, 0, 1'b1, 8'h20, mk(0, 1, 3'd7, 2'd3, 3'd1, 10'h3C1), "");
        step(1'b1, 32'h20DE_AD00, 1'b0, 0, 0, "R7");
        // R3, R10: back-to-back mix of hits and misses
        step(1'b1, 32'hFF00_0001, 1'b0, 0, 0, "R3");
        step(1'b1, 32'h2000_0002, 1'b0, 0, 0, "R10");
        step(1'b1, 32'h30FE_DCBA, 1'b0, 0, 0, "R3");
        step(1'b1, 32'h7F00_0000, 1'b0, 0, 0, "R10");
        step(1'b1, 32'h1000_0003, 1'b0, 0, 0, "R3");
        // R2: boot entry can itself be reprogrammed
        step(1'b0, 0, 1'b1, 8'hFF, mk(1, 0, 3'd4, 2'd2, 3'd2, 10'h0AB), "");
        step(1'b1, 32'hFF00_BEEF, 1'b0, 0, 0, "R2");
        idle(4);
        check(sb_q.size() == 0, "R3",
              $sformatf("pending act=%0d exp=0", sb_q.size()));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule